// File: doc/BRIEF.md
# Multicycle Register-Transfer Processor Core

This block is a compact 32-bit processor core that runs each instruction as a short sequence of numbered control states. One 5-bit state register drives a datapath built around a program counter, a memory address register, a memory data register, an instruction register and a 32-entry register file. A three-state fetch reads the next word. The opcode then selects a per-instruction execute sequence of one to three states, and the machine returns to fetch.

The core talks to a synchronous word memory through one address port, one write-data port, one read-data port and one write strobe. Read data arrives in the cycle after the address is presented. The address port carries the value the memory address register is taking at the next edge, so the memory captures the address on the same edge as that register does. Branches test a single register against zero directly. There is no condition-code register. All byte addresses are word aligned.

Top module: `mc_core`

## Requirements
- R1: Fetch takes three cycles. In the first, mem_addr_o equals PC. In the second, the memory word is captured. In the third, the instruction register is loaded and PC advances by 4 through its own adder. Instruction fields: opcode [31:26], rd [25:21], rs1 [20:16], rs2 [15:11], imm16 [15:0], off26 [25:0]. Execute starts in the fourth cycle in the state whose number equals the opcode.
- R2: Opcodes 3..8 are register-register ADD, SUB, MUL (low 32 bits), DIV (unsigned; a zero divisor gives all ones), AND and OR. Each writes rs1 op rs2 to rd, and the instruction takes 4 cycles.
- R3: Opcodes 9..14 are ADDI and SUBI (sign-extended imm16), ANDI and ORI (zero-extended imm16), and SHL and SHR (logical shift by imm16[4:0]). Each writes to rd in 4 cycles.
- R4: Opcode 15 is a load. In cycle 4, mem_addr_o equals rs1 + sext(imm16). The word returned is written to rd, and the instruction takes 6 cycles.
- R5: Opcode 18 is a store of the register named in [25:21] to rs1 + sext(imm16). That address is on mem_addr_o in cycle 4. mem_we_o is high in cycle 6 only, with the same address and the register value on mem_wdata_o. The instruction takes 6 cycles.
- R6: Opcodes 21 (less than), 23 (greater than), 25 (equal) and 27 (not equal) compare rs1, taken as signed, against zero. Each takes 5 cycles. When the test holds, PC becomes PC+4 + sext(imm16)*4. Otherwise PC stays at PC+4.
- R7: Opcode 29 is a relative jump to PC+4 + sext(off26)*4 in 4 cycles.
- R8: Opcode 30 is an indirect jump to rs1 + sext(imm16) in 4 cycles.
- R9: Opcode 31 writes PC+4 into r31 and then jumps like opcode 29. It takes 5 cycles and shares the jump state.
- R10: Register r0 always reads as zero, and writes to it are dropped.
- R11: Any other opcode returns to fetch after the three fetch cycles. It changes no register and no memory, and PC only advances by 4.
- R12: While rst_ni is low, the state is 0, PC is 0, mem_addr_o is 0 and mem_we_o is 0. The first fetch after release reads address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_addr_o | output | 32 | Byte address into word memory (next MAR value) |
| mem_wdata_o | output | 32 | Store data |
| mem_rdata_i | input | 32 | Read data, valid the cycle after the address |
| mem_we_o | output | 1 | Write strobe for one cycle |

## Verification
Instruction lengths are fixed per class: 3 cycles for an undefined opcode, 4 for ALU operations and jumps, 5 for branches and jump-and-link, and 6 for loads and stores. A reference model in the bench executes the program at instruction level and expands each instruction into that many expected cycles. A fetch address is due on the port in the first cycle of every instruction. A load or store address is due in cycle 4, and a store strobe with its data in cycle 6. The bench compares the ports against that per-cycle list once per clock, half a period after the edge, so every wrong target, latency or write shows up as a misplaced fetch or store. Register results reach the ports through a final block of stores, and the written memory is compared word by word at the end.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RAW  = $clog2(NREG);
  localparam int OPW  = 6;
  localparam int STW  = 5;

  typedef enum logic [STW-1:0] {
    S_FADDR = 5'd0, S_FREAD, S_FLOAD,
    S_ADD, S_SUB, S_MUL, S_DIV, S_AND, S_OR,
    S_ADDI, S_SUBI, S_ANDI, S_ORI, S_SHL, S_SHR,
    S_LADDR, S_LREAD, S_LWB,
    S_SADDR, S_SDATA, S_SWR,
    S_BLT, S_BLT_T, S_BGT, S_BGT_T, S_BEQ, S_BEQ_T, S_BNE, S_BNE_T,
    S_JREL, S_JIND, S_JLINK
  } state_e;

  typedef enum logic [2:0] {
    A_ADD, A_SUB, A_MUL, A_DIV, A_AND, A_OR, A_SHL, A_SHR
  } alu_op_e;

  function automatic logic op_valid(logic [OPW-1:0] op);
    return op inside {[6'd3:6'd15], 6'd18, 6'd21, 6'd23, 6'd25, 6'd27, [6'd29:6'd31]};
  endfunction
endpackage

// File: rtl/mc_regfile.sv
module mc_regfile
  import mc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [RAW-1:0]  ra_i,
  input  logic [RAW-1:0]  rb_i,
  output logic [XLEN-1:0] ra_o,
  output logic [XLEN-1:0] rb_o,
  input  logic            we_i,
  input  logic [RAW-1:0]  wa_i,
  input  logic [XLEN-1:0] wd_i
);
  logic [XLEN-1:0] rf_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) rf_q[i] <= '0;
    end else if (we_i && wa_i != '0) begin
      rf_q[wa_i] <= wd_i;
    end
  end

  assign ra_o = (ra_i == '0) ? '0 : rf_q[ra_i];
  assign rb_o = (rb_i == '0) ? '0 : rf_q[rb_i];
endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
(
  input  alu_op_e         op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] y_o
);
  localparam int SHW = $clog2(XLEN);

  always_comb begin
    unique case (op_i)
      A_ADD:   y_o = a_i + b_i;
      A_SUB:   y_o = a_i - b_i;
      A_MUL:   y_o = a_i * b_i;
      A_DIV:   y_o = (b_i == '0) ? '1 : a_i / b_i;
      A_AND:   y_o = a_i & b_i;
      A_OR:    y_o = a_i | b_i;
      A_SHL:   y_o = a_i << b_i[SHW-1:0];
      A_SHR:   y_o = a_i >> b_i[SHW-1:0];
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [OPW-1:0] op_i,
  output state_e         state_o
);
  state_e state_d;

  always_comb begin
    unique case (state_o)
      S_FADDR: state_d = S_FREAD;
      S_FREAD: state_d = S_FLOAD;
      S_FLOAD: state_d = op_valid(op_i) ? state_e'(op_i[STW-1:0]) : S_FADDR;
      S_LADDR: state_d = S_LREAD;
      S_LREAD: state_d = S_LWB;
      S_SADDR: state_d = S_SDATA;
      S_SDATA: state_d = S_SWR;
      S_BLT:   state_d = S_BLT_T;
      S_BGT:   state_d = S_BGT_T;
      S_BEQ:   state_d = S_BEQ_T;
      S_BNE:   state_d = S_BNE_T;
      S_JLINK: state_d = S_JREL;
      default: state_d = S_FADDR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= S_FADDR;
    else         state_o <= state_d;
  end
endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [XLEN-1:0] mem_addr_o,
  output logic [XLEN-1:0] mem_wdata_o,
  input  logic [XLEN-1:0] mem_rdata_i,
  output logic            mem_we_o
);
  state_e          state_q;
  logic [XLEN-1:0] pc_q, pc_d, mar_q, mar_d, mdr_q, mdr_d, ir_q;
  logic            cond_q, cond_d;
  logic [XLEN-1:0] ra, rb, alu_b, alu_y, rf_wd;
  logic [XLEN-1:0] imm_s, imm_z, off16, off26, pc_inc;
  logic [RAW-1:0]  rb_addr, rf_wa;
  logic            rf_we;
  alu_op_e         alu_op;

  mc_ctrl u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (mdr_q[31:26]),
    .state_o(state_q)
  );

  assign imm_s   = {{(XLEN-16){ir_q[15]}}, ir_q[15:0]};
  assign imm_z   = {{(XLEN-16){1'b0}}, ir_q[15:0]};
  assign off16   = {imm_s[XLEN-3:0], 2'b00};
  assign off26   = {{(XLEN-28){ir_q[25]}}, ir_q[25:0], 2'b00};
  assign pc_inc  = pc_q + XLEN'(4);
  // store data register sits in the rd field
  assign rb_addr = (state_q == S_SDATA) ? ir_q[25:21] : ir_q[15:11];

  mc_regfile u_rf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ra_i  (ir_q[20:16]),
    .rb_i  (rb_addr),
    .ra_o  (ra),
    .rb_o  (rb),
    .we_i  (rf_we),
    .wa_i  (rf_wa),
    .wd_i  (rf_wd)
  );

  always_comb begin
    alu_op = A_ADD;
    alu_b  = imm_s;
    unique case (state_q)
      S_ADD:  begin alu_op = A_ADD; alu_b = rb; end
      S_SUB:  begin alu_op = A_SUB; alu_b = rb; end
      S_MUL:  begin alu_op = A_MUL; alu_b = rb; end
      S_DIV:  begin alu_op = A_DIV; alu_b = rb; end
      S_AND:  begin alu_op = A_AND; alu_b = rb; end
      S_OR:   begin alu_op = A_OR;  alu_b = rb; end
      S_SUBI: alu_op = A_SUB;
      S_ANDI: begin alu_op = A_AND; alu_b = imm_z; end
      S_ORI:  begin alu_op = A_OR;  alu_b = imm_z; end
      S_SHL:  begin alu_op = A_SHL; alu_b = imm_z; end
      S_SHR:  begin alu_op = A_SHR; alu_b = imm_z; end
      default: ;
    endcase
  end

  mc_alu u_alu (.op_i(alu_op), .a_i(ra), .b_i(alu_b), .y_o(alu_y));

  always_comb begin
    rf_we = state_q inside {[S_ADD:S_SHR], S_LWB, S_JLINK};
    rf_wa = (state_q == S_JLINK) ? RAW'(NREG-1) : ir_q[25:21];
    unique case (state_q)
      S_LWB:   rf_wd = mdr_q;
      S_JLINK: rf_wd = pc_q;
      default: rf_wd = alu_y;
    endcase
  end

  always_comb begin
    pc_d   = pc_q;
    mar_d  = mar_q;
    mdr_d  = mdr_q;
    cond_d = cond_q;
    unique case (state_q)
      S_FADDR: mar_d = pc_q;
      S_FREAD, S_LREAD: mdr_d = mem_rdata_i;
      S_FLOAD: pc_d = pc_inc;
      S_LADDR, S_SADDR: mar_d = alu_y;
      S_SDATA: mdr_d = rb;
      S_BLT:   cond_d = ra[XLEN-1];
      S_BGT:   cond_d = !ra[XLEN-1] && (ra != '0);
      S_BEQ:   cond_d = (ra == '0);
      S_BNE:   cond_d = (ra != '0);
      S_BLT_T, S_BGT_T, S_BEQ_T, S_BNE_T: if (cond_q) pc_d = pc_q + off16;
      S_JREL:  pc_d = pc_q + off26;
      S_JIND:  pc_d = alu_y;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      mar_q  <= '0;
      mdr_q  <= '0;
      ir_q   <= '0;
      cond_q <= 1'b0;
    end else begin
      pc_q   <= pc_d;
      mar_q  <= mar_d;
      mdr_q  <= mdr_d;
      cond_q <= cond_d;
      if (state_q == S_FLOAD) ir_q <= mdr_q;
    end
  end

  assign mem_addr_o  = mar_d;
  assign mem_wdata_o = mdr_q;
  assign mem_we_o    = (state_q == S_SWR);
endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk
  import mc_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic [STW-1:0]  state_i,
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] mdr_i,
  input logic [XLEN-1:0] ir_i,
  input logic            cond_i,
  input logic            mem_we_i
);
  // R1
  fetch_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == S_FADDR |=> state_i == S_FREAD);
  // R1
  fetch_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == S_FREAD |=> state_i == S_FLOAD);
  // R1
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == S_FLOAD |=> pc_i == $past(pc_i) + 32'd4);
  // R5
  store_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> $past(state_i) == S_SDATA);
  // R6
  branch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i inside {S_BLT_T, S_BGT_T, S_BEQ_T, S_BNE_T} && !cond_i) |=> $stable(pc_i));
  // R10
  r0_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_SDATA && ir_i[25:21] == 5'd0) |=> mdr_i == '0);
  // R11
  undef_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_FLOAD && !op_valid(mdr_i[31:26])) |=> state_i == S_FADDR);
endmodule

bind mc_core mc_core_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .state_i (state_q),
  .pc_i    (pc_q),
  .mdr_i   (mdr_q),
  .ir_i    (ir_q),
  .cond_i  (cond_q),
  .mem_we_i(mem_we_o)
);

// File: tb/sim_mc_core.sv
module sim_mc_core;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  mc_core u0 (
    .clk_i(clk), .rst_ni(rst_ni), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_we_o(mem_we)
  );

  logic [31:0] mem [256];
  logic [31:0] mm  [256];
  logic [31:0] r   [32];

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[9:2]];
  end

  logic        exp_chk[$];
  logic [31:0] exp_addr[$];
  logic        exp_we[$];
  logic [31:0] exp_wd[$];
  string       exp_tag[$];

  task automatic push(input logic c, input logic [31:0] a, input logic w,
                      input logic [31:0] d, input string t);
    exp_chk.push_back(c); exp_addr.push_back(a); exp_we.push_back(w);
    exp_wd.push_back(d);  exp_tag.push_back(t);
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(logic [5:0] op, logic [4:0] rd, logic [4:0] s1, logic [4:0] s2);
    return {op, rd, s1, s2, 11'd0};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rd, logic [4:0] s1, logic [15:0] im);
    return {op, rd, s1, im};
  endfunction
  function automatic logic [31:0] enc_j(logic [5:0] op, logic [25:0] off);
    return {op, off};
  endfunction

  localparam logic [31:0] HALT_W = {6'd29, 26'h3FFFFFF};

  task automatic put(input int idx, input logic [31:0] w);
    mem[idx] = w; mm[idx] = w;
  endtask

  task automatic load_prog();
    for (int i = 0; i < 256; i++) begin mem[i] = '0; mm[i] = '0; end
    put(0,  enc_i(9, 1, 0, 16'd100));
    put(1,  enc_i(9, 2, 0, 16'hFFFD));
    put(2,  enc_r(3, 3, 1, 2));
    put(3,  enc_r(4, 4, 2, 1));
    put(4,  enc_r(5, 5, 1, 2));
    put(5,  enc_r(6, 6, 1, 2));
    put(6,  enc_r(6, 7, 1, 0));
    put(7,  enc_r(7, 8, 1, 2));
    put(8,  enc_r(8, 9, 1, 2));
    put(9,  enc_i(11, 10, 2, 16'hF0F0));
    put(10, enc_i(12, 11, 0, 16'h8001));
    put(11, enc_i(10, 12, 1, 16'h7FFF));
    put(12, enc_i(13, 13, 1, 16'h0024));
    put(13, enc_i(14, 14, 2, 16'd28));
    put(14, enc_i(9, 0, 1, 16'd5));
    put(15, enc_i(18, 1, 0, 16'h0200));
    put(16, enc_i(15, 15, 0, 16'h0200));
    put(17, enc_i(21, 0, 2, 16'd1));
    put(18, enc_i(9, 16, 0, 16'd1));
    put(19, enc_i(23, 0, 2, 16'd1));
    put(20, enc_i(9, 17, 0, 16'd2));
    put(21, enc_i(25, 0, 0, 16'd1));
    put(22, enc_i(9, 16, 0, 16'd3));
    put(23, enc_i(27, 0, 0, 16'd5));
    put(24, 32'hFC3F_FFFF);
    put(25, enc_j(31, 26'd2));
    put(26, enc_i(9, 18, 0, 16'd7));
    put(27, enc_i(9, 18, 0, 16'd8));
    put(28, enc_i(30, 0, 31, 16'd16));
    put(29, enc_i(9, 19, 0, 16'd9));
    put(30, enc_j(29, 26'd1));
    put(31, enc_i(9, 19, 0, 16'd10));
    for (int k = 0; k < 32; k++) put(32 + k, enc_i(18, 5'(k), 0, 16'(16'h0280 + 4 * k)));
    put(64, HALT_W);
  endtask

  // instruction-level reference, expanded into expected per-cycle port values
  task automatic build_expect();
    logic [31:0] pc = '0, ins, a, npc, ims, imz;
    logic [5:0]  op;
    logic [4:0]  rd, s1, s2;
    string       prev = "R12", tg;
    int          halts = 0;
    for (int i = 0; i < 32; i++) r[i] = '0;
    for (int n = 0; n < 400 && halts < 3; n++) begin
      ins = mm[pc[9:2]];
      op = ins[31:26]; rd = ins[25:21]; s1 = ins[20:16]; s2 = ins[15:11];
      ims = {{16{ins[15]}}, ins[15:0]}; imz = {16'd0, ins[15:0]};
      push(1, pc, 0, 0, prev); push(0, 0, 0, 0, "R1"); push(0, 0, 0, 0, "R1");
      npc = pc + 4;
      tg = "R11";
      case (op)
        3, 4, 5, 6, 7, 8: begin
          tg = "R2";
          case (op)
            3: a = r[s1] + r[s2];
            4: a = r[s1] - r[s2];
            5: a = r[s1] * r[s2];
            6: a = (r[s2] == 0) ? 32'hFFFF_FFFF : r[s1] / r[s2];
            7: a = r[s1] & r[s2];
            default: a = r[s1] | r[s2];
          endcase
          r[rd] = a; push(0, 0, 0, 0, tg);
        end
        9, 10, 11, 12, 13, 14: begin
          tg = "R3";
          case (op)
            9:  a = r[s1] + ims;
            10: a = r[s1] - ims;
            11: a = r[s1] & imz;
            12: a = r[s1] | imz;
            13: a = r[s1] << ins[4:0];
            default: a = r[s1] >> ins[4:0];
          endcase
          r[rd] = a; push(0, 0, 0, 0, tg);
        end
        15: begin
          tg = "R4"; a = r[s1] + ims;
          push(1, a, 0, 0, tg); push(0, 0, 0, 0, tg); push(0, 0, 0, 0, tg);
          r[rd] = mm[a[9:2]];
        end
        18: begin
          tg = "R5"; a = r[s1] + ims;
          push(1, a, 0, 0, tg); push(0, 0, 0, 0, tg);
          push(1, a, 1, r[rd], (rd == 0) ? "R10" : "R5");
          mm[a[9:2]] = r[rd];
        end
        21, 23, 25, 27: begin
          tg = "R6";
          push(0, 0, 0, 0, tg); push(0, 0, 0, 0, tg);
          if ((op == 21 && $signed(r[s1]) < 0) || (op == 23 && $signed(r[s1]) > 0) ||
              (op == 25 && r[s1] == 0) || (op == 27 && r[s1] != 0))
            npc = npc + {ims[29:0], 2'b00};
        end
        29: begin
          tg = "R7"; push(0, 0, 0, 0, tg);
          npc = npc + {{4{ins[25]}}, ins[25:0], 2'b00};
        end
        30: begin
          tg = "R8"; push(0, 0, 0, 0, tg);
          npc = r[s1] + ims;
        end
        31: begin
          tg = "R9"; push(0, 0, 0, 0, tg); push(0, 0, 0, 0, tg);
          r[31] = npc;
          npc = npc + {{4{ins[25]}}, ins[25:0], 2'b00};
        end
        default: ;
      endcase
      r[0] = '0;
      if (ins == HALT_W) halts++;
      prev = tg; pc = npc;
    end
  endtask

  initial begin
    load_prog();
    build_expect();
    repeat (3) @(negedge clk);
    #1;
    check(mem_we === 1'b0, "R12", "reset we", {31'd0, mem_we}, 32'd0);
    check(mem_addr === 32'd0, "R12", "reset addr", mem_addr, 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    while (exp_we.size() > 0) begin
      logic c, w;
      logic [31:0] ea, ed;
      string t;
      #1;
      c = exp_chk.pop_front(); ea = exp_addr.pop_front(); w = exp_we.pop_front();
      ed = exp_wd.pop_front(); t = exp_tag.pop_front();
      check(mem_we === w, t, "mem_we", {31'd0, mem_we}, {31'd0, w});
      if (c) check(mem_addr === ea, t, "mem_addr", mem_addr, ea);
      if (w) check(mem_wdata === ed, t, "mem_wdata", mem_wdata, ed);
      @(negedge clk);
    end
    for (int i = 128; i < 192; i++)
      check(mem[i] === mm[i], "R5", "memory word", mem[i], mm[i]);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R1 watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule